// File: doc/BRIEF.md
# Streaming Radix-2 Delay-Feedback FFT Stage

This block is one stage of a pipelined radix-2 decimation-in-frequency FFT. It takes one complex sample per accepted clock and returns one complex sample per accepted clock. Each stage holds a delay line of `DEPTH` entries, one butterfly and a small routing network. A counter running modulo `2*DEPTH` over accepted samples splits every block into two halves. In the first half the arriving samples are parked in the delay line, while the delay line's older contents leave as output. In the second half the oldest parked sample is paired with the arriving one. Their sum is sent out, and their difference, rotated by a twiddle factor, goes back into the delay line.

To build an N-point transform, chain log2(N) stages whose depths are N/2, N/4, ..., 1. Twiddle factors are supplied from outside: the stage presents an index and reads the factor back in the same cycle. Every stage changes the fixed-point reading of its data by one bit. Raw output values are twice the arithmetic result, so the same word width carries one more fraction bit and one less integer bit. Overflow clamps to the extreme codes. A parameter turns a stage into the front stage of a zero-padded transform. In that mode the second half of every block is taken to be zero and the adders drop away.

Top module: `sdf_fft_stage`

## Requirements
- R1: While `rst` is high, and after it, until the first accepted sample: `out_valid` is 0, `out_re`/`out_im` are 0, and `tw_idx` is 0.
- R2: Accepted samples are numbered modulo 2*DEPTH, starting at 0 after reset. Counts 0..DEPTH-1 form the fill half and DEPTH..2*DEPTH-1 the pair half. During the pair half, `tw_idx` equals count minus DEPTH.
- R3: `out_valid` is high in the cycle after each accepted sample, except the first DEPTH samples after reset. It is low in every other cycle. The first output follows the sample numbered DEPTH.
- R4: The output caused by pair-half sample k+DEPTH is sat(2*(h+x)), computed per real and imaginary part. Here x is the arriving sample and h is the fill-half sample k of the same block.
- R5: The output caused by fill-half sample k of the next block is sat(floor(P / 2^(TW_W-3))). P is the complex product (h-x)*(tw_re + j*tw_im), taken with the twiddle value presented while `tw_idx` was k. The twiddle code carries TW_W-2 fraction bits.
- R6: sat() clamps to 2^(W-1)-1 when above that and to -2^(W-1) when below.
- R7: While `in_valid` is low, `out_re`, `out_im` and `tw_idx` hold their values and no sample is consumed.
- R8: With ZERO_PAD=1, inputs during the pair half have no effect on any output. Sums become sat(2*h) and differences use h alone.
- R9: Stages of depth 4, 2 and 1 in series give 8 times the 8-point DFT of each block, in bit-reversed bin order, to within 16 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample accepted this cycle |
| in_re | input | W | Input real part, two's complement |
| in_im | input | W | Input imaginary part |
| tw_idx | output | max(1,log2 DEPTH) | Twiddle index for the current pair-half sample |
| tw_re | input | TW_W | Twiddle real part, TW_W-2 fraction bits |
| tw_im | input | TW_W | Twiddle imaginary part |
| out_valid | output | 1 | Output sample present |
| out_re | output | W | Output real part |
| out_im | output | W | Output imaginary part |

## Verification
A counter that slips by one count mislabels the halves. The fault shows at the ports within one block of 2*DEPTH samples: sums appear where rotated differences belong, `tw_idx` reads the wrong value, and `out_valid` rises one cycle early or late. A delay-line entry that is lost or stale corrupts the pairing partner of a sample in the next half-block. That sum is wrong at most DEPTH accepted samples after the bad write, and the matching rotated difference is wrong DEPTH samples later. Saturation faults appear only on the extreme-value blocks, and only in the cycle when the clamped value leaves the stage.

// File: rtl/sdf_fft_pkg.sv
package sdf_fft_pkg;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_PAIR = 1'b1
    } phase_e;

    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/sdf_fft_delay.sv
module sdf_fft_delay #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] tap [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
        end else if (en) begin
            tap[0] <= din;
            for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
        end
    end

    assign dout = tap[DEPTH-1];

endmodule

// File: rtl/sdf_fft_ctrl.sv
module sdf_fft_ctrl
    import sdf_fft_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(2 * DEPTH),
    localparam int IW = idx_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output phase_e        phase,
    output logic          primed,
    output logic [IW-1:0] tw_idx
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            primed <= 1'b0;
        end else if (en) begin
            cnt <= cnt + CW'(1);
            if (phase == PH_PAIR) primed <= 1'b1;
        end
    end

    // upper half of the count range is the pairing half
    assign phase = phase_e'(cnt[CW-1]);

    generate
        if (DEPTH > 1) begin : g_idx
            assign tw_idx = cnt[IW-1:0];
        end else begin : g_idx_one
            assign tw_idx = '0;
        end
    endgenerate

endmodule

// File: rtl/sdf_fft_sat.sv
module sdf_fft_sat #(
    parameter int IN_W  = 34,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);

    localparam longint HI_L = (64'sd1 <<< (OUT_W - 1)) - 64'sd1;
    localparam longint LO_L = -HI_L - 64'sd1;
    localparam logic signed [IN_W-1:0] HI = IN_W'(HI_L);
    localparam logic signed [IN_W-1:0] LO = IN_W'(LO_L);

    always_comb begin
        if (din > HI)      dout = HI[OUT_W-1:0];
        else if (din < LO) dout = LO[OUT_W-1:0];
        else               dout = din[OUT_W-1:0];
    end

endmodule

// File: rtl/sdf_fft_bfly.sv
module sdf_fft_bfly #(
    parameter int W    = 16,
    parameter int TW_W = 16
) (
    input  logic signed [W-1:0]    a_re,
    input  logic signed [W-1:0]    a_im,
    input  logic signed [W-1:0]    b_re,
    input  logic signed [W-1:0]    b_im,
    input  logic signed [TW_W-1:0] w_re,
    input  logic signed [TW_W-1:0] w_im,
    output logic signed [W-1:0]    s_re,
    output logic signed [W-1:0]    s_im,
    output logic signed [W-1:0]    d_re,
    output logic signed [W-1:0]    d_im
);

    localparam int SW    = W + 2;
    localparam int DW    = W + 1;
    localparam int PW    = DW + TW_W + 1;
    localparam int SH    = TW_W - 3;
    localparam int LANES = 4;

    logic signed [SW-1:0] sum_re, sum_im;
    logic signed [DW-1:0] dif_re, dif_im;
    logic signed [PW-1:0] rot_re, rot_im, rsh_re, rsh_im;
    logic signed [PW-1:0] lane_in  [LANES];
    logic signed [W-1:0]  lane_out [LANES];

    always_comb begin
        // doubling moves the binary point one place for the next stage
        sum_re = (SW'(a_re) + SW'(b_re)) <<< 1;
        sum_im = (SW'(a_im) + SW'(b_im)) <<< 1;
        dif_re = DW'(a_re) - DW'(b_re);
        dif_im = DW'(a_im) - DW'(b_im);
        rot_re = (PW'(dif_re) * PW'(w_re)) - (PW'(dif_im) * PW'(w_im));
        rot_im = (PW'(dif_re) * PW'(w_im)) + (PW'(dif_im) * PW'(w_re));
        rsh_re = rot_re >>> SH;
        rsh_im = rot_im >>> SH;
        lane_in[0] = PW'(sum_re);
        lane_in[1] = PW'(sum_im);
        lane_in[2] = rsh_re;
        lane_in[3] = rsh_im;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_sat
        sdf_fft_sat #(.IN_W(PW), .OUT_W(W)) u_sat (
            .din  (lane_in[g]),
            .dout (lane_out[g])
        );
    end

    assign s_re = lane_out[0];
    assign s_im = lane_out[1];
    assign d_re = lane_out[2];
    assign d_im = lane_out[3];

endmodule

// File: rtl/sdf_fft_stage.sv
module sdf_fft_stage
    import sdf_fft_pkg::*;
#(
    parameter int W        = 16,
    parameter int TW_W     = 16,
    parameter int DEPTH    = 16,
    parameter bit ZERO_PAD = 1'b0,
    localparam int IW = idx_width(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [W-1:0]    in_re,
    input  logic signed [W-1:0]    in_im,
    output logic [IW-1:0]          tw_idx,
    input  logic signed [TW_W-1:0] tw_re,
    input  logic signed [TW_W-1:0] tw_im,
    output logic                   out_valid,
    output logic signed [W-1:0]    out_re,
    output logic signed [W-1:0]    out_im
);

    phase_e phase;
    logic   primed;
    logic [2*W-1:0] head, fifo_din;
    logic signed [W-1:0] head_re, head_im, b_re, b_im;
    logic signed [W-1:0] s_re, s_im, d_re, d_im, nx_re, nx_im;

    sdf_fft_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .en     (in_valid),
        .phase  (phase),
        .primed (primed),
        .tw_idx (tw_idx)
    );

    sdf_fft_delay #(.DW(2 * W), .DEPTH(DEPTH)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .en   (in_valid),
        .din  (fifo_din),
        .dout (head)
    );

    assign head_re = head[2*W-1:W];
    assign head_im = head[W-1:0];

    generate
        if (ZERO_PAD) begin : g_pad
            assign b_re = '0;
            assign b_im = '0;
        end else begin : g_full
            assign b_re = in_re;
            assign b_im = in_im;
        end
    endgenerate

    sdf_fft_bfly #(.W(W), .TW_W(TW_W)) u_bfly (
        .a_re (head_re),
        .a_im (head_im),
        .b_re (b_re),
        .b_im (b_im),
        .w_re (tw_re),
        .w_im (tw_im),
        .s_re (s_re),
        .s_im (s_im),
        .d_re (d_re),
        .d_im (d_im)
    );

    // routing network
    always_comb begin
        if (phase == PH_PAIR) begin
            fifo_din = {d_re, d_im};
            nx_re    = s_re;
            nx_im    = s_im;
        end else begin
            fifo_din = {in_re, in_im};
            nx_re    = head_re;
            nx_im    = head_im;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= in_valid && (primed || phase == PH_PAIR);
            if (in_valid) begin
                out_re <= nx_re;
                out_im <= nx_im;
            end
        end
    end

endmodule

// File: rtl/sdf_fft_stage_chk.sv
module sdf_fft_stage_chk #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [IW-1:0]       tw_idx,
    input logic                out_valid,
    input logic signed [W-1:0] out_re,
    input logic signed [W-1:0] out_im
);

    logic [31:0] seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= '0;
        else if (in_valid && seen != '1) seen <= seen + 32'd1;
    end

    // R3
    no_early_output_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen > 32'(DEPTH)));

    // R3
    valid_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R3
    steady_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seen >= 32'(DEPTH)) |=> out_valid);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im)));

    // R7
    twiddle_index_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(tw_idx));

endmodule

bind sdf_fft_stage sdf_fft_stage_chk #(.W(W), .DEPTH(DEPTH), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .tw_idx    (tw_idx),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/sdf_fft_stage_bench.sv
module sdf_fft_stage_bench;

    localparam int W    = 16;
    localparam int TW_W = 16;
    localparam int D    = 4;
    localparam int BL   = 2 * D;
    localparam int NBLK = 40;
    localparam int NIN  = (NBLK + 1) * BL;
    localparam int NCB  = 6;
    localparam int NCIN = (NCB + 2) * 8;
    localparam real PI  = 3.14159265358979;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // single stage stimulus, shared by the full and zero-padded instances
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_re = '0, in_im = '0;
    logic [1:0] tw_idx, zp_tw_idx;
    logic signed [TW_W-1:0] tw_re, tw_im, zp_tw_re, zp_tw_im;
    logic out_valid, zp_valid;
    logic signed [W-1:0] out_re, out_im, zp_re, zp_im;

    int twr_tab[D], twi_tab[D];
    int xr[NIN], xi[NIN];

    assign tw_re    = TW_W'(twr_tab[tw_idx]);
    assign tw_im    = TW_W'(twi_tab[tw_idx]);
    assign zp_tw_re = TW_W'(twr_tab[zp_tw_idx]);
    assign zp_tw_im = TW_W'(twi_tab[zp_tw_idx]);

    sdf_fft_stage #(.W(W), .TW_W(TW_W), .DEPTH(D), .ZERO_PAD(1'b0)) u_sdf_fft_stage (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .tw_idx(tw_idx), .tw_re(tw_re), .tw_im(tw_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im));

    sdf_fft_stage #(.W(W), .TW_W(TW_W), .DEPTH(D), .ZERO_PAD(1'b1)) u_zp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .tw_idx(zp_tw_idx), .tw_re(zp_tw_re), .tw_im(zp_tw_im),
        .out_valid(zp_valid), .out_re(zp_re), .out_im(zp_im));

    // three-stage chain for an 8-point transform
    logic c_v = 1'b0;
    logic signed [W-1:0] c_re = '0, c_im = '0;
    logic [1:0] c0_idx;
    logic c1_idx, c2_idx;
    logic signed [TW_W-1:0] c0_twr, c0_twi, c1_twr, c1_twi, c2_twr, c2_twi;
    logic v01, v12, c_ov;
    logic signed [W-1:0] r01, i01, r12, i12, c_ore, c_oim;
    int cxr[NCIN], cxi[NCIN];

    function automatic logic signed [TW_W-1:0] tw_val(input int k, input int d, input bit imag);
        real ang;
        int v;
        ang = 2.0 * PI * real'(k) / (2.0 * real'(d));
        if (imag) v = int'(-16384.0 * $sin(ang));
        else      v = int'(16384.0 * $cos(ang));
        return TW_W'(v);
    endfunction

    assign c0_twr = tw_val(int'(c0_idx), 4, 1'b0);
    assign c0_twi = tw_val(int'(c0_idx), 4, 1'b1);
    assign c1_twr = tw_val(int'(c1_idx), 2, 1'b0);
    assign c1_twi = tw_val(int'(c1_idx), 2, 1'b1);
    assign c2_twr = tw_val(int'(c2_idx), 1, 1'b0);
    assign c2_twi = tw_val(int'(c2_idx), 1, 1'b1);

    sdf_fft_stage #(.W(W), .TW_W(TW_W), .DEPTH(4)) u_c0 (
        .clk(clk), .rst(rst), .in_valid(c_v), .in_re(c_re), .in_im(c_im),
        .tw_idx(c0_idx), .tw_re(c0_twr), .tw_im(c0_twi),
        .out_valid(v01), .out_re(r01), .out_im(i01));
    sdf_fft_stage #(.W(W), .TW_W(TW_W), .DEPTH(2)) u_c1 (
        .clk(clk), .rst(rst), .in_valid(v01), .in_re(r01), .in_im(i01),
        .tw_idx(c1_idx), .tw_re(c1_twr), .tw_im(c1_twi),
        .out_valid(v12), .out_re(r12), .out_im(i12));
    sdf_fft_stage #(.W(W), .TW_W(TW_W), .DEPTH(1)) u_c2 (
        .clk(clk), .rst(rst), .in_valid(v12), .in_re(r12), .in_im(i12),
        .tw_idx(c2_idx), .tw_re(c2_twr), .tw_im(c2_twi),
        .out_valid(c_ov), .out_re(c_ore), .out_im(c_oim));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat_w(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // unclamped expected value of output j of a single stage
    function automatic void model(input int j, input bit zp, output longint er,
                                  output longint ei, output bit is_sum);
        int b, r, k, a, c;
        longint hr, hi, yr, yi, dr, di;
        b = j / BL;
        r = j % BL;
        k = (r < D) ? r : r - D;
        a = b * BL + k;
        c = a + D;
        hr = xr[a];
        hi = xi[a];
        yr = zp ? 0 : xr[c];
        yi = zp ? 0 : xi[c];
        is_sum = (r < D);
        if (is_sum) begin
            er = 2 * (hr + yr);
            ei = 2 * (hi + yi);
        end else begin
            dr = hr - yr;
            di = hi - yi;
            er = (dr * twr_tab[k] - di * twi_tab[k]) >>> (TW_W - 3);
            ei = (dr * twi_tab[k] + di * twr_tab[k]) >>> (TW_W - 3);
        end
    endfunction

    task automatic check_sample(input int j, input bit zp, input longint ar, input longint ai);
        longint er, ei;
        bit is_sum;
        string tag;
        model(j, zp, er, ei, is_sum);
        if (zp) tag = "R8";
        else if (er != sat_w(er) || ei != sat_w(ei)) tag = "R6";
        else tag = is_sum ? "R4" : "R5";
        check(ar == sat_w(er), tag, $sformatf("re of output %0d", j), ar, sat_w(er));
        check(ai == sat_w(ei), tag, $sformatf("im of output %0d", j), ai, sat_w(ei));
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // accepted-sample bookkeeping at the active edge
    int n_acc = 0;
    bit prev_v = 1'b0;
    always @(posedge clk) begin
        prev_v <= !rst && in_valid;
        if (!rst && in_valid) n_acc <= n_acc + 1;
    end

    int oj = 0, zj = 0;
    longint last_re = 0, last_im = 0;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            // R3 valid timing
            check(out_valid == (prev_v && n_acc > D), "R3", "out_valid",
                  longint'(out_valid), longint'(prev_v && n_acc > D));
            if (out_valid) begin
                check_sample(oj, 1'b0, longint'(out_re), longint'(out_im));
                last_re = out_re;
                last_im = out_im;
                oj++;
            end else if (oj > 0) begin
                // R7 hold while idle
                check(longint'(out_re) == last_re && longint'(out_im) == last_im,
                      "R7", "held output", longint'(out_re), last_re);
            end
            if (zp_valid) begin
                check_sample(zj, 1'b1, longint'(zp_re), longint'(zp_im));
                zj++;
            end
            // R2 twiddle index in the pairing half
            if ((n_acc % BL) >= D)
                check(int'(tw_idx) == (n_acc % BL) - D, "R2", "tw_idx",
                      longint'(tw_idx), longint'((n_acc % BL) - D));
        end
    end

    function automatic int bitrev3(input int r);
        return ((r & 1) << 2) | (r & 2) | ((r >> 2) & 1);
    endfunction

    int cj = 0;
    always @(negedge clk) begin
        if (!rst && !finished && c_ov) begin
            int b, k;
            real sr, si, ang;
            b = cj / 8;
            if (b < NCB) begin
                k = bitrev3(cj % 8);
                sr = 0.0;
                si = 0.0;
                for (int n = 0; n < 8; n++) begin
                    ang = 2.0 * PI * real'(n * k) / 8.0;
                    sr += real'(cxr[b*8+n]) * $cos(ang) + real'(cxi[b*8+n]) * $sin(ang);
                    si += real'(cxi[b*8+n]) * $cos(ang) - real'(cxr[b*8+n]) * $sin(ang);
                end
                sr *= 8.0;
                si *= 8.0;
                // R9 chained transform
                check((real'(c_ore) - sr) <= 16.0 && (sr - real'(c_ore)) <= 16.0,
                      "R9", $sformatf("re bin %0d block %0d", k, b), longint'(c_ore), longint'($rtoi(sr)));
                check((real'(c_oim) - si) <= 16.0 && (si - real'(c_oim)) <= 16.0,
                      "R9", $sformatf("im bin %0d block %0d", k, b), longint'(c_oim), longint'($rtoi(si)));
            end
            cj++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        twr_tab[0] = 16384;  twi_tab[0] = 0;
        twr_tab[1] = -32768; twi_tab[1] = 32767;
        for (int k = 2; k < D; k++) begin
            twr_tab[k] = int'($urandom_range(65535)) - 32768;
            twi_tab[k] = int'($urandom_range(65535)) - 32768;
        end
        for (int n = 0; n < NIN; n++) begin
            int b, h;
            b = n / BL;
            h = (n % BL) < D ? 0 : 1;
            case (b)
                0: begin xr[n] = 32767;  xi[n] = 32767;  end
                1: begin xr[n] = -32768; xi[n] = -32768; end
                2: begin xr[n] = h ? -32768 : 32767; xi[n] = h ? 32767 : -32768; end
                3: begin xr[n] = 0; xi[n] = 0; end
                4: begin xr[n] = h ? 32767 : -32768; xi[n] = 1; end
                default: begin
                    if (b == NBLK) begin
                        xr[n] = 0; xi[n] = 0;
                    end else if (b % 2 == 1) begin
                        xr[n] = int'($urandom_range(65535)) - 32768;
                        xi[n] = int'($urandom_range(65535)) - 32768;
                    end else begin
                        xr[n] = int'($urandom_range(400)) - 200;
                        xi[n] = int'($urandom_range(400)) - 200;
                    end
                end
            endcase
        end
        for (int n = 0; n < NCIN; n++) begin
            if (n < NCB * 8) begin
                cxr[n] = int'($urandom_range(128)) - 64;
                cxi[n] = int'($urandom_range(128)) - 64;
            end else begin
                cxr[n] = 0;
                cxi[n] = 0;
            end
        end

        // R1 reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        check(out_re == '0 && out_im == '0, "R1", "output data in reset", longint'(out_re), 0);
        check(tw_idx == '0, "R1", "tw_idx in reset", longint'(tw_idx), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_re == '0, "R1", "idle after reset", longint'(out_valid), 0);

        for (int n = 0; n < NIN; ) begin
            @(negedge clk);
            if ($urandom_range(3) == 0) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_re = W'(xr[n]);
                in_im = W'(xi[n]);
                n++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        check(oj == NIN - D, "R3", "output count", longint'(oj), longint'(NIN - D));
        check(zj == NIN - D, "R8", "padded output count", longint'(zj), longint'(NIN - D));

        for (int n = 0; n < NCIN; n++) begin
            c_v = 1'b1;
            c_re = W'(cxr[n]);
            c_im = W'(cxi[n]);
            @(negedge clk);
        end
        c_v = 1'b0;
        repeat (10) @(negedge clk);
        check(cj >= NCB * 8, "R9", "chain output count", longint'(cj), longint'(NCB * 8));
        finish_run();
    end

endmodule